// File: doc/BRIEF.md
# Banked Global Register Switch

This block holds the eight global registers of a processor core and keeps four complete copies of them: a normal set, an alternate set, a memory-management set and an interrupt set. Exactly one copy is visible at a time. The choice is made by three bits of a 12-bit processor-state register that the block owns. The core writes the globals through one write port and reads them through two independent combinational read ports. It updates the processor-state register through a separate write port.

A processor-state write that changes the bank selection hides the current set and exposes another. No data moves. The hidden set stays untouched until it is selected again. The switch is done by changing a bank index, so the new set is readable on the cycle after the state write, with no stall. A build parameter can remove the alternate set from reach by forcing its selection bit to zero on every state write.

Top module: `gbank_top`

## Requirements
- R1: After reset the processor-state output is 0 and every register in every bank reads as 0.
- R2: A processor-state write stores the written value ANDed with 0xF3F, so bits 6 and 7 always read as 0. The stored value appears on the state output on the cycle after the write. Without a write the state output holds its value.
- R3: When the parameter ALT_OFF is 1, bit 0 of every processor-state write is stored as 0, so the alternate bank can never be selected.
- R4: Bank selection looks at state bits 11, 10 and 0. If none is set, the normal bank is active. Bit 0 alone selects the alternate bank, bit 10 alone the memory-management bank, and bit 11 alone the interrupt bank.
- R5: Any combination with two or more of bits 11, 10 and 0 set selects the normal bank.
- R6: A register write stores data into the addressed register of the active bank. Both read ports return it from the next cycle on.
- R7: After a state write that changes the selection, reads return the incoming bank's contents from the next cycle on. The outgoing bank's contents are preserved and reappear when that bank is selected again.
- R8: A state write that leaves the selection unchanged (for example, one that only changes bit 5) leaves the visible register contents unchanged.
- R9: A register write and a state write in the same cycle put the data into the outgoing bank, not the incoming one.
- R10: The two read ports are independent. Each returns the active-bank register at its own address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Global register write enable |
| wrAddr | input | 3 | Global register write address |
| wrData | input | 64 | Global register write data |
| rdAddrA | input | 3 | Read port A address |
| rdDataA | output | 64 | Read port A data, active bank |
| rdAddrB | input | 3 | Read port B address |
| rdDataB | output | 64 | Read port B data, active bank |
| stateWrEn | input | 1 | Processor-state write enable |
| stateWrData | input | 12 | Processor-state write value |
| stateOut | output | 12 | Stored processor-state value |

## Verification
The bench builds two copies of the block side by side, driven by the same inputs.

- **ALT_OFF = 0.** This copy exercises all four banks, the illegal selection combinations, and the same-cycle write-and-switch case.
- **ALT_OFF = 1.** This copy shows that a write of bit 0 never reaches the state register and that such a write leaves the normal bank visible.

Together the two copies bring both values of the feature parameter within reach, with 64-bit data and eight registers per bank.

// File: rtl/gbank_pkg.sv
package gbank_pkg;
  localparam int NUM_BANKS = 4;
  localparam int STATE_W = 12;
  localparam logic [STATE_W-1:0] STATE_KEEP = 12'hF3F;
  localparam int SEL_ALT_BIT = 0;
  localparam int SEL_MMU_BIT = 10;
  localparam int SEL_INTR_BIT = 11;

  typedef enum logic [1:0] {
    BANK_NORMAL = 2'd0,
    BANK_ALT    = 2'd1,
    BANK_MMU    = 2'd2,
    BANK_INTR   = 2'd3
  } bank_e;

  typedef struct packed {
    logic  regWe;
    bank_e bank;
  } gbank_strobe_t;

  function automatic bank_e decodeBank(logic [STATE_W-1:0] s);
    bank_e b;
    case ({s[SEL_INTR_BIT], s[SEL_MMU_BIT], s[SEL_ALT_BIT]})
      3'b001:  b = BANK_ALT;
      3'b010:  b = BANK_MMU;
      3'b100:  b = BANK_INTR;
      default: b = BANK_NORMAL;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/gbank_ctrl.sv
module gbank_ctrl
  import gbank_pkg::*;
#(
  parameter bit ALT_OFF = 1'b0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               stateWrEn,
  input  logic [STATE_W-1:0] stateWrData,
  output logic [STATE_W-1:0] stateQ,
  output gbank_strobe_t      strobe
);
  localparam logic [STATE_W-1:0] ALT_CLR = ~(STATE_W'(1) << SEL_ALT_BIT);
  localparam logic [STATE_W-1:0] WR_MASK = ALT_OFF ? (STATE_KEEP & ALT_CLR) : STATE_KEEP;

  logic [STATE_W-1:0] stateNext;

  always_comb begin
    stateNext = stateQ;
    if (stateWrEn) stateNext = stateWrData & WR_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= '0;
    else       stateQ <= stateNext;
  end

  // The bank follows the stored state, so a same-cycle register write
  // lands in the bank that is still active (the outgoing one).
  always_comb begin
    strobe.regWe = wrEn;
    strobe.bank  = decodeBank(stateQ);
  end
endmodule

// File: rtl/gbank_dp.sv
module gbank_dp
  import gbank_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int NUM_REGS = 8,
  localparam int ADDR_W = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  gbank_strobe_t     strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataB
);
  logic [DATA_W-1:0] regFile [NUM_BANKS][NUM_REGS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      logic hit;
      assign hit = strobe.regWe && (strobe.bank == bank_e'(b)) && (wrAddr == ADDR_W'(r));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)    regFile[b][r] <= '0;
        else if (hit) regFile[b][r] <= wrData;
      end
    end
  end

  assign rdDataA = regFile[strobe.bank][rdAddrA];
  assign rdDataB = regFile[strobe.bank][rdAddrB];
endmodule

// File: rtl/gbank_top.sv
module gbank_top
  import gbank_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int NUM_REGS = 8,
  parameter bit ALT_OFF = 1'b0,
  localparam int ADDR_W = $clog2(NUM_REGS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [ADDR_W-1:0]  rdAddrA,
  output logic [DATA_W-1:0]  rdDataA,
  input  logic [ADDR_W-1:0]  rdAddrB,
  output logic [DATA_W-1:0]  rdDataB,
  input  logic               stateWrEn,
  input  logic [STATE_W-1:0] stateWrData,
  output logic [STATE_W-1:0] stateOut
);
  gbank_strobe_t strobe;

  gbank_ctrl #(.ALT_OFF(ALT_OFF)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn),
    .stateWrEn(stateWrEn), .stateWrData(stateWrData),
    .stateQ(stateOut), .strobe(strobe)
  );

  gbank_dp #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrAddr(wrAddr), .wrData(wrData),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB)
  );
endmodule

// File: rtl/gbank_chk.sv
module gbank_chk
  import gbank_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int NUM_REGS = 8,
  parameter bit ALT_OFF = 1'b0,
  localparam int ADDR_W = $clog2(NUM_REGS)
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  wrAddr,
  input logic [DATA_W-1:0]  wrData,
  input logic [ADDR_W-1:0]  rdAddrA,
  input logic [DATA_W-1:0]  rdDataA,
  input logic [ADDR_W-1:0]  rdAddrB,
  input logic [DATA_W-1:0]  rdDataB,
  input logic               stateWrEn,
  input logic [STATE_W-1:0] stateWrData,
  input logic [STATE_W-1:0] stateOut
);
  logic [STATE_W-1:0] wrKept;
  assign wrKept = stateWrData & STATE_KEEP & (ALT_OFF ? 12'hFFE : 12'hFFF);

  AST_STATE_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut & ~STATE_KEEP) == '0); // R2

  AST_STATE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    stateWrEn |=> stateOut == $past(wrKept)); // R2

  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stateWrEn |=> $stable(stateOut)); // R2

  AST_ALT_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    ALT_OFF |-> !stateOut[SEL_ALT_BIT]); // R3

  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !stateWrEn) ##1 (rdAddrA == $past(wrAddr)) |-> rdDataA == $past(wrData)); // R6

  AST_SAME_SEL_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (stateWrEn && !wrEn && decodeBank(wrKept) == decodeBank(stateOut))
      ##1 (rdAddrB == $past(rdAddrB)) |-> rdDataB == $past(rdDataB)); // R8
endmodule

bind gbank_top gbank_chk #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ALT_OFF(ALT_OFF)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
  .stateWrEn(stateWrEn), .stateWrData(stateWrData), .stateOut(stateOut)
);

// File: tb/gbank_top_tb_top.sv
`timescale 1ns/1ps
module gbank_top_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [63:0] wrData = '0;
  logic [2:0]  rdAddrA = '0, rdAddrB = '0;
  logic        stateWrEn = 1'b0;
  logic [11:0] stateWrData = '0;
  logic [63:0] rdA0, rdB0, rdA1, rdB1;
  logic [11:0] st0, st1;

  gbank_top #(.ALT_OFF(1'b0)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddrA(rdAddrA), .rdDataA(rdA0), .rdAddrB(rdAddrB), .rdDataB(rdB0),
    .stateWrEn(stateWrEn), .stateWrData(stateWrData), .stateOut(st0));

  gbank_top #(.ALT_OFF(1'b1)) dutNoAlt_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddrA(rdAddrA), .rdDataA(rdA1), .rdAddrB(rdAddrB), .rdDataB(rdB1),
    .stateWrEn(stateWrEn), .stateWrData(stateWrData), .stateOut(st1));

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  string phaseTag = "R1";

  // Reference model: per instance, four banks of eight 64-bit values.
  logic [63:0] mRegs [2][4][8];
  logic [11:0] mState [2];

  function automatic int selOf(logic [11:0] s);
    if (s[0] && !s[10] && !s[11]) return 1;
    if (!s[0] && s[10] && !s[11]) return 2;
    if (!s[0] && !s[10] && s[11]) return 3;
    return 0;
  endfunction

  function automatic logic [11:0] keepOf(int k, logic [11:0] v);
    logic [11:0] r;
    r = v & 12'hF3F;
    if (k == 1) r[0] = 1'b0;
    return r;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < 2; k++) begin
        mState[k] <= '0;
        for (int b = 0; b < 4; b++)
          for (int r = 0; r < 8; r++) mRegs[k][b][r] <= '0;
      end
    end else begin
      for (int k = 0; k < 2; k++) begin
        if (wrEn) mRegs[k][selOf(mState[k])][wrAddr] <= wrData;
        if (stateWrEn) mState[k] <= keepOf(k, stateWrData);
      end
    end
  end

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h at %0t", phaseTag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("state0", 64'(st0), 64'(mState[0]));
      chk("rdA0", rdA0, mRegs[0][selOf(mState[0])][rdAddrA]);
      chk("rdB0", rdB0, mRegs[0][selOf(mState[0])][rdAddrB]);
      chk("state1", 64'(st1), 64'(mState[1]));
      chk("rdA1", rdA1, mRegs[1][selOf(mState[1])][rdAddrA]);
      chk("rdB1", rdB1, mRegs[1][selOf(mState[1])][rdAddrB]);
    end
  end

  task automatic step(bit we, int wa, logic [63:0] wd, bit se, logic [11:0] sd, int ra, int rb);
    @(negedge clk);
    #1;
    wrEn = we; wrAddr = 3'(wa); wrData = wd;
    stateWrEn = se; stateWrData = sd;
    rdAddrA = 3'(ra); rdAddrB = 3'(rb);
  endtask

  task automatic fillBank(logic [11:0] sel);
    step(0, 0, '0, 1, sel, 0, 0);
    for (int r = 0; r < 8; r++) step(1, r, {$urandom, $urandom}, 0, '0, r, 7 - r);
    for (int r = 0; r < 8; r++) step(0, 0, '0, 0, '0, r, (r + 3) % 8);
  endtask

  task automatic sweep();
    for (int r = 0; r < 8; r++) step(0, 0, '0, 0, '0, r, 7 - r);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    phaseTag = "R1";  sweep();
    phaseTag = "R6";  fillBank(12'h000);
    phaseTag = "R4";  fillBank(12'h001); fillBank(12'h400); fillBank(12'h800);
    phaseTag = "R7";
    foreach (mState[k]) begin end
    step(0, 0, '0, 1, 12'h000, 0, 0); sweep();
    step(0, 0, '0, 1, 12'h400, 0, 0); sweep();
    step(0, 0, '0, 1, 12'h001, 0, 0); sweep();
    phaseTag = "R5";
    step(0, 0, '0, 1, 12'h401, 0, 0); sweep();
    step(0, 0, '0, 1, 12'hC00, 0, 0); sweep();
    step(0, 0, '0, 1, 12'h801, 0, 0); sweep();
    step(0, 0, '0, 1, 12'hC01, 0, 0); sweep();
    phaseTag = "R2";
    step(0, 0, '0, 1, 12'hFFF, 0, 0); step(0, 0, '0, 0, '0, 1, 2);
    step(0, 0, '0, 1, 12'h0C0, 0, 0); step(0, 0, '0, 0, '0, 3, 4);
    phaseTag = "R3";
    step(0, 0, '0, 1, 12'h001, 0, 0); sweep();
    step(0, 0, '0, 1, 12'h03F, 0, 0); sweep();
    phaseTag = "R8";
    step(0, 0, '0, 1, 12'h800, 0, 0); sweep();
    step(0, 0, '0, 1, 12'h820, 0, 0); sweep();
    step(0, 0, '0, 1, 12'h8DF & 12'hFFE, 0, 0); sweep();
    phaseTag = "R9";
    step(1, 2, 64'hA5A5_0000_1111_2222, 1, 12'h400, 2, 2); sweep();
    step(1, 5, 64'h5A5A_3333_4444_5555, 1, 12'h800, 5, 5); sweep();
    step(0, 0, '0, 1, 12'h400, 0, 0); sweep();
    phaseTag = "R10";
    for (int i = 0; i < 64; i++) step(0, 0, '0, 0, '0, i % 8, (i / 8) % 8);
    phaseTag = "R7";
    for (int i = 0; i < 400; i++) begin
      logic [11:0] s;
      case ($urandom % 6)
        0: s = 12'h000; 1: s = 12'h001; 2: s = 12'h400;
        3: s = 12'h800; 4: s = 12'hC01; default: s = 12'($urandom);
      endcase
      step(($urandom % 2) == 0, $urandom % 8, {$urandom, $urandom},
           ($urandom % 4) == 0, s, $urandom % 8, $urandom % 8);
    end
    step(0, 0, '0, 0, '0, 0, 0);
    @(negedge clk);
    finishRun();
  end
endmodule